// File: doc/BRIEF.md
# Scannable Registered Bus Transceiver

This block is a small bidirectional transceiver that sits between a local data path and a shared wired-OR bus. A transmit register holds the word that is driven onto the bus. A receive register captures the resolved bus value and presents it on the receive outputs. Each register either loads new data or recirculates its own value, under a separate load enable for each side. The data path is non-inverting in both directions.

The bus drive enable is kept in its own flip-flop. That flip-flop samples a synchronous enable on each clock. An asynchronous kill input removes bus drive at once, without a clock, and also clears the flip-flop. A mode input chooses how drive comes back once the kill is released. When it is low, drive returns immediately. When it is high, drive returns only after a clock edge that samples the synchronous enable high.

A disabled driver outputs zeros, so the other drivers decide the bus value. In scan mode all seven state bits form one serial chain, which is read out at the most significant receive output.

Top module: `scan_bus_xcvr`

## Requirements
- R1: With `tx_load` high at a rising clock edge, the transmit register takes `tx_data` unchanged. While bus drive is on, `bus_out` equals that register.
- R2: With `tx_load` low and `scan_mode` low, the transmit register keeps its value whatever `tx_data` does.
- R3: With `rx_load` high at a rising edge, `rx_q` takes the resolved bus value that was present just before that edge.
- R4: With `rx_load` low and `scan_mode` low, `rx_q` keeps its value whatever the bus does.
- R5: The resolved bus is the bitwise OR of `bus_ext` and, only when `bus_drive` is 1, the transmit register.
- R6: With `bus_kill` low and `reenable_sync` high, `bus_drive` after a rising edge equals the `bus_en_sync` value sampled at that edge.
- R7: While `bus_kill` is high, `bus_drive` is 0 at once, with no clock needed, and the enable flip-flop is cleared. With `reenable_sync` high, drive stays off after the kill is released until a rising edge samples `bus_en_sync` high.
- R8: With `reenable_sync` low, `bus_drive` is 1 whenever `bus_kill` is low, including straight after the kill is released and with no clock.
- R9: Whenever `bus_drive` is 0, `bus_out` is all zeros.
- R10: With `scan_mode` high, each rising edge shifts the chain `scan_in` → tx[0] → tx[1] → tx[2] → enable → rx[0] → rx[1] → rx[2]. Shifting takes priority over `tx_load`, `rx_load` and `bus_en_sync`. The chain output is `rx_q[2]`. After 7 shifts of the bits b0 (first) to b6, the state is `rx_q` = {b0,b1,b2}, enable = b3, and tx[2:0] = {b4,b5,b6}.
- R11: After reset, every register is 0. `bus_drive` is 0 while `reenable_sync` is high, and `bus_out` and `rx_q` are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all registers |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| tx_data | input | 3 | Word to transmit |
| tx_load | input | 1 | 1 loads `tx_data`, 0 holds the transmit register |
| rx_load | input | 1 | 1 captures the resolved bus, 0 holds the receive register |
| bus_en_sync | input | 1 | Synchronous bus-drive enable, sampled on the clock |
| bus_kill | input | 1 | Asynchronous bus disable, active high |
| reenable_sync | input | 1 | 1: re-enable waits for a clock; 0: re-enable at once (active-low set) |
| scan_mode | input | 1 | 1 turns the registers into one shift chain |
| scan_in | input | 1 | Serial scan data input |
| bus_ext | input | 3 | OR of the other drivers on the bus |
| bus_out | output | 3 | This block's bus drive value; zeros when cut off |
| bus_drive | output | 1 | 1 while this block drives the bus |
| rx_q | output | 3 | Receive register; `rx_q[2]` is also the scan output |

## Verification
The data path is swept over all 8 transmit words against all 8 external bus words, once with drive on and once with drive off. This separates the OR merge from plain pass-through and shows that the cutoff value is zero. In each step the load input is changed while the other data input moves, which tells hold apart from load on each side. The enable is driven through kill pulses placed between clock edges, once in each re-enable mode, to separate the immediate return from the clocked one. All 128 seven-bit scan patterns are shifted in while the load enables are held active. This checks both the chain order and the priority of shifting over loading.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned XCVR_W = 3;
  // tx bits, the enable bit, then rx bits
  localparam int unsigned CHAIN_LEN = 2 * XCVR_W + 1;
  typedef logic [XCVR_W-1:0] xword_t;
endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/xcvr_bank.sv
module xcvr_bank #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic         sin,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  // Per-bit next state: shifting wins over loading, otherwise loop back
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic chain_src;
    if (i == 0) begin : g_head
      assign chain_src = sin;
    end else begin : g_link
      assign chain_src = q[i-1];
    end
    always_comb begin
      if (shift)     q_d[i] = chain_src;
      else if (load) q_d[i] = d[i];
      else           q_d[i] = q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  // R2 / R4: hold path keeps the value
  p_hold_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift && !load) |=> $stable(q));
  // R1 / R3: load path takes the data word
  p_load_takes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift && load) |=> (q == $past(d)));
  // R10: shift moves one place toward the tail
  p_shift_moves_r10: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> (q[0] == $past(sin)));
endmodule

// File: rtl/xcvr_drive_en.sv
module xcvr_drive_en (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic shift,
  input  logic sin,
  input  logic sync_en,
  input  logic reen_sync,
  output logic en_q
);
  logic en_d;

  always_comb begin
    if (shift)           en_d = sin;
    else if (!reen_sync) en_d = 1'b1;
    else                 en_d = sync_en;
  end

  // kill clears the flag at once; clocked capture otherwise
  always_ff @(posedge clk or negedge rst_n or posedge kill) begin
    if (!rst_n)    en_q <= 1'b0;
    else if (kill) en_q <= 1'b0;
    else           en_q <= en_d;
  end

  p_kill_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> !en_q);
  p_shift_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !kill) |=> (kill || en_q == $past(sin)));
endmodule

// File: rtl/scan_bus_xcvr.sv
module scan_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tx_data,
  input  logic         tx_load,
  input  logic         rx_load,
  input  logic         bus_en_sync,
  input  logic         bus_kill,
  input  logic         reenable_sync,
  input  logic         scan_mode,
  input  logic         scan_in,
  input  logic [W-1:0] bus_ext,
  output logic [W-1:0] bus_out,
  output logic         bus_drive,
  output logic [W-1:0] rx_q
);
  logic         rst_sn;
  logic [W-1:0] tx_q;
  logic         en_q;
  logic [W-1:0] bus_res;

  xcvr_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  xcvr_bank #(.W(W)) u_tx (
    .clk   (clk),
    .rst_n (rst_sn),
    .load  (tx_load),
    .shift (scan_mode),
    .sin   (scan_in),
    .d     (tx_data),
    .q     (tx_q)
  );

  xcvr_drive_en u_en (
    .clk       (clk),
    .rst_n     (rst_sn),
    .kill      (bus_kill),
    .shift     (scan_mode),
    .sin       (tx_q[W-1]),
    .sync_en   (bus_en_sync),
    .reen_sync (reenable_sync),
    .en_q      (en_q)
  );

  // Cutoff driver: no drive while killed; async set when re-enable is immediate
  assign bus_drive = !bus_kill && (en_q || !reenable_sync);
  assign bus_out   = bus_drive ? tx_q : '0;
  assign bus_res   = bus_out | bus_ext;

  xcvr_bank #(.W(W)) u_rx (
    .clk   (clk),
    .rst_n (rst_sn),
    .load  (rx_load),
    .shift (scan_mode),
    .sin   (en_q),
    .d     (bus_res),
    .q     (rx_q)
  );

  p_cutoff_zero_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    !bus_drive |-> (bus_out == '0));
  p_kill_off_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    bus_kill |-> !bus_drive);
  p_fast_reenable_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (!reenable_sync && !bus_kill) |-> bus_drive);
  p_rx_capture_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (rx_load && !scan_mode) |=> (rx_q == ($past(bus_ext) | $past(bus_out))));
endmodule

// File: tb/sim_scan_bus_xcvr.sv
module sim_scan_bus_xcvr;
  localparam int CLK_PERIOD = 10;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic         tx_load = 1'b0;
  logic         rx_load = 1'b0;
  logic         bus_en_sync = 1'b0;
  logic         bus_kill = 1'b0;
  logic         reenable_sync = 1'b1;
  logic         scan_mode = 1'b0;
  logic         scan_in = 1'b0;
  logic [W-1:0] bus_ext = '0;
  logic [W-1:0] bus_out;
  logic         bus_drive;
  logic [W-1:0] rx_q;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_bus_xcvr #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_load(tx_load),
    .rx_load(rx_load), .bus_en_sync(bus_en_sync), .bus_kill(bus_kill),
    .reenable_sync(reenable_sync), .scan_mode(scan_mode), .scan_in(scan_in),
    .bus_ext(bus_ext), .bus_out(bus_out), .bus_drive(bus_drive), .rx_q(rx_q)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    // R11 reset state
    check("R11 drive", int'(bus_drive), 0);
    check("R11 bus_out", int'(bus_out), 0);
    check("R11 rx_q", int'(rx_q), 0);

    // R1..R5, R9: sweep tx word x external word, drive off then on
    for (int dv = 0; dv < 2; dv++) begin
      bus_en_sync = dv[0];
      tick();
      check("R6 drive follows sync enable", int'(bus_drive), dv);
      for (int a = 0; a < 8; a++) begin
        for (int e = 0; e < 8; e++) begin
          tx_data = W'(a); bus_ext = W'(e); tx_load = 1'b1; rx_load = 1'b0;
          tick();
          tx_load = 1'b0; rx_load = 1'b1;
          tick();
          rx_load = 1'b0;
          check("R1 bus_out", int'(bus_out), dv ? a : 0);
          check("R9 cutoff", int'(bus_out == '0), dv ? int'(a == 0) : 1);
          check("R3 R5 rx capture", int'(rx_q), (dv ? a : 0) | e);
          // R2 / R4 hold: move the data inputs with loads low
          tx_data = ~W'(a); bus_ext = ~W'(e);
          tick();
          check("R2 tx hold", int'(bus_out), dv ? a : 0);
          check("R4 rx hold", int'(rx_q), (dv ? a : 0) | e);
        end
      end
    end

    // R7: kill with clocked re-enable
    bus_ext = '0; tx_data = 3'b101; tx_load = 1'b1; bus_en_sync = 1'b1;
    tick();
    tx_load = 1'b0;
    check("R6 drive on", int'(bus_drive), 1);
    bus_kill = 1'b1; #1;
    check("R7 immediate off", int'(bus_drive), 0);
    check("R9 off zero", int'(bus_out), 0);
    #1 bus_kill = 1'b0; bus_en_sync = 1'b0; #1;
    check("R7 stays off after release", int'(bus_drive), 0);
    tick();
    check("R7 off with sync low", int'(bus_drive), 0);
    bus_en_sync = 1'b1;
    tick();
    check("R7 on after clocked enable", int'(bus_drive), 1);
    check("R1 value back", int'(bus_out), 5);

    // R8: immediate re-enable
    reenable_sync = 1'b0; bus_en_sync = 1'b0;
    bus_kill = 1'b1; #1;
    check("R8 kill wins", int'(bus_drive), 0);
    #1 bus_kill = 1'b0; #1;
    check("R8 immediate return", int'(bus_drive), 1);
    tick();
    check("R8 ignores sync low", int'(bus_drive), 1);
    reenable_sync = 1'b1;
    tick();

    // R10: full scan sweep with loads active to show shift priority
    for (int p = 0; p < 128; p++) begin
      scan_mode = 1'b1; tx_load = 1'b1; rx_load = 1'b1; bus_en_sync = 1'b1;
      tx_data = 3'b111; bus_ext = 3'b111;
      for (int k = 0; k < 7; k++) begin
        scan_in = p[k];
        tick();
      end
      scan_mode = 1'b0; tx_load = 1'b0; rx_load = 1'b0; bus_ext = '0;
      #1;
      check("R10 rx bits", int'(rx_q), p[0] * 4 + p[1] * 2 + p[2]);
      check("R10 enable bit", int'(bus_drive), p[3]);
      check("R10 tx bits", int'(bus_out), p[3] ? (p[4] * 4 + p[5] * 2 + p[6]) : 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule